// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave on a two-wire bus with a clock line and an open-drain data line. It gives a host access to a bank of 8-bit control registers, which the rest of the chip reads from a flat output vector. It also exposes a set of read-only status bytes that the chip supplies on an input vector. Both bus lines are brought into the system clock domain through two-flop synchronizers. All protocol decisions are taken on edges detected there. The block never drives the data line high. It only asserts a pull-low enable, and the pad turns that into an open-drain output.

The device answers to two fixed bus addresses. 24h opens a write transfer and 25h opens a read transfer, so the 7-bit device address is 12h followed by a direction bit. In a write, the first byte after the address loads an internal byte index. Every later byte lands at that index, and the index then steps by one. A host that wants to read first sets the index in a write transfer. It then issues a start, either after a stop or as a repeated start, with the read address and clocks out as many bytes as it likes. The index steps after each byte in this direction too. Bursts have no length limit in either direction, and the index wraps modulo 256.

The index space is laid out as follows. Indices 0 to NUM_CTRL-1 are the control registers. The NUM_STAT indices that follow are the status bytes. Every higher index is unmapped. Unmapped indices read as 00h and ignore writes.

Top module: `twowire_regslave`

## Requirements
- R1: A falling data line while the clock is high is a start condition. It aborts any transfer in progress, and the next eight clocks form an address byte.
- R2: A rising data line while the clock is high is a stop condition. It releases the data line, and the slave stays silent, with no acknowledge and no register change, until the next start.
- R3: The slave acknowledges address byte 24h (write) and 25h (read) by pulling the data line low during the ninth clock. Any other address gets no acknowledge, and the slave ignores the bus until the next start.
- R4: Bytes are received MSB first. In a write, the first byte after the address loads the index. Each following byte is acknowledged and stored in control register [index], after which the index steps by one.
- R5: A write byte aimed at a status index or an unmapped index is still acknowledged and still steps the index, but it changes no control register.
- R6: In a read, the slave sends the byte at the current index MSB first: a control register, the live status byte (taken when that byte starts), or 00h if unmapped. The index steps after every byte and keeps its value across a stop.
- R7: After the eighth bit of a read byte the slave releases the line. A master acknowledge (line low on the ninth clock) makes it send the next byte. A master not-acknowledge leaves the line released until the next start.
- R8: During and after reset, every control register holds its value from CTRL_INIT (register i in bits 8i+7..8i), the index is 0 and the pull-low enable is off.
- R9: The index is 8 bits wide and wraps from FFh to 00h during a burst.
- R10: The slave changes its pull-low enable only while the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| sda_pull_o | output | 1 | Pull data line low when 1, release when 0 |
| status_i | input | NUM_STAT*8 | Read-only status bytes; byte j is index NUM_CTRL+j |
| ctrl_o | output | NUM_CTRL*8 | Control register contents; register i in bits 8i+7..8i |

## Verification
On every cycle, assertions enforce a set of local rules. The pull-low enable moves only while the clock is low, and a stop or start puts the slave into its idle or address phase on the next cycle. An idle or ignoring slave never pulls the line. Control registers change only on the clock edge that ends a write data byte, and the index moves only by a load or a single step, wrapping included. Other behaviour needs the bench's transfers. These are the address match, the mapping of indices to control, status and unmapped space, burst continuation after a master acknowledge versus silence after a not-acknowledge, an index that survives a stop, and repeated starts in the middle of a write.

// File: rtl/twowire_regslave.sv
module twowire_regslave #(
  parameter int NUM_CTRL = 8,
  parameter int NUM_STAT = 4,
  parameter logic [6:0] DEV_ADDR = 7'h12,
  parameter logic [NUM_CTRL*8-1:0] CTRL_INIT = 64'h0F00_3220_2001_0081
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  input  logic [NUM_STAT*8-1:0] status_i,
  output logic [NUM_CTRL*8-1:0] ctrl_o
);
  localparam int STAT_END = NUM_CTRL + NUM_STAT;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_INDEX, ST_WDATA, ST_RDATA, ST_SKIP} state_t;

  logic [2:0] scl_pipe, sda_pipe;
  logic       scl_s, scl_p, sda_s, sda_p;
  logic       scl_rise, scl_fall, start_evt, stop_evt;

  state_t     state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txreg, idx, rd_byte;
  logic       mack;
  logic       wr_go;
  logic [7:0] ctrl_q [NUM_CTRL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= 3'b111;
      sda_pipe <= 3'b111;
    end else begin
      scl_pipe <= {scl_pipe[1:0], scl_i};
      sda_pipe <= {sda_pipe[1:0], sda_i};
    end
  end

  assign scl_s     = scl_pipe[1];
  assign scl_p     = scl_pipe[2];
  assign sda_s     = sda_pipe[1];
  assign sda_p     = sda_pipe[2];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NUM_CTRL; i++)
      if (idx == 8'(i)) rd_byte = ctrl_q[i];
    for (int j = 0; j < NUM_STAT; j++)
      if (idx == 8'(NUM_CTRL + j)) rd_byte = status_i[j*8 +: 8];
  end

  assign wr_go = (state == ST_WDATA) && scl_fall && (bitcnt == 4'd8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTRL; i++) ctrl_q[i] <= CTRL_INIT[i*8 +: 8];
    end else if (wr_go) begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (idx == 8'(i)) ctrl_q[i] <= shreg;
    end
  end

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_out
    assign ctrl_o[g*8 +: 8] = ctrl_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= 4'd0;
      shreg      <= 8'h00;
      txreg      <= 8'h00;
      idx        <= 8'h00;
      mack       <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (start_evt) begin
      state      <= ST_ADDR;
      bitcnt     <= 4'd0;
      sda_pull_o <= 1'b0;
    end else if (stop_evt) begin
      state      <= ST_IDLE;
      bitcnt     <= 4'd0;
      sda_pull_o <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_INDEX, ST_WDATA: begin
          if (scl_rise && bitcnt < 4'd9) begin
            if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          if (scl_fall && bitcnt == 4'd8) begin
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_pull_o <= 1'b1;
                state      <= shreg[0] ? ST_RDATA : ST_INDEX;
              end else begin
                state <= ST_SKIP;
              end
            end else if (state == ST_INDEX) begin
              idx        <= shreg;
              sda_pull_o <= 1'b1;
              state      <= ST_WDATA;
            end else begin
              idx        <= idx + 8'd1;
              sda_pull_o <= 1'b1;
            end
          end
          if (scl_fall && bitcnt == 4'd9) begin
            sda_pull_o <= 1'b0;
            bitcnt     <= 4'd0;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            if (bitcnt == 4'd8) begin
              mack   <= ~sda_s;
              bitcnt <= 4'd9;
            end else if (bitcnt < 4'd8) begin
              bitcnt <= bitcnt + 4'd1;
            end
          end
          if (scl_fall) begin
            if (bitcnt == 4'd9) begin
              bitcnt <= 4'd0;
              if (mack) begin
                txreg      <= rd_byte;
                sda_pull_o <= ~rd_byte[7];
              end else begin
                state      <= ST_SKIP;
                sda_pull_o <= 1'b0;
              end
            end else if (bitcnt == 4'd8) begin
              sda_pull_o <= 1'b0;
              idx        <= idx + 8'd1;
            end else if (bitcnt != 4'd0) begin
              txreg      <= {txreg[6:0], 1'b0};
              sda_pull_o <= ~txreg[6];
            end
          end
        end
        default: sda_pull_o <= 1'b0;
      endcase
    end
  end

  assert_start_enters_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR && bitcnt == 4'd0));

  assert_stop_frees_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_pull_o));

  assert_silent_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_pull_o);

  assert_ctrl_only_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == ST_WDATA && scl_fall && bitcnt == 4'd8) |=> $stable(ctrl_o));

  assert_index_steps_by_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx) && $past(state) != ST_INDEX) |-> (idx == $past(idx) + 8'd1));

  assert_pull_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s));
endmodule

// File: tb/twowire_regslave_test.sv
module twowire_regslave_test;
  localparam int NC = 8;
  localparam int NS = 4;
  localparam int H  = 16;
  localparam logic [63:0] INIT = 64'h0F00_3220_2001_0081;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull;
  wire  sda_bus = m_sda & ~sda_pull;
  logic [NC*8-1:0] ctrl;
  logic [NS*8-1:0] stat = 32'hDEAD_BEEF;

  twowire_regslave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .status_i(stat), .ctrl_o(ctrl)
  );

  int checks = 0, fails = 0;
  logic [7:0] exp_ctrl [NC];
  int m_idx = 0;
  int quiet = 0;
  logic last_scl = 1'b1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_vec();
    logic [63:0] v;
    for (int i = 0; i < NC; i++) v[i*8 +: 8] = exp_ctrl[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input int i);
    if (i < NC) return exp_ctrl[i];
    if (i < NC + NS) return stat[(i-NC)*8 +: 8];
    return 8'h00;
  endfunction

  // reference compare on every quiet clock (R4/R5 state of the control bank)
  always @(negedge clk) begin
    #1;
    if (m_scl != last_scl) quiet = 0; else quiet++;
    last_scl = m_scl;
    if (rst_n && quiet >= 6) check(ctrl == exp_vec(), "R4/R5 control bank", ctrl, exp_vec());
  end

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tk(4);
    m_scl = 1'b1; tk(H);
    m_sda = 1'b0; tk(H);
    m_scl = 1'b0; tk(H/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tk(4);
    m_scl = 1'b1; tk(H);
    m_sda = 1'b1; tk(H);
  endtask

  // kind: 0 address, 1 index, 2 data
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input int kind, input string req);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tk(H/2);
      m_scl = 1'b1; tk(H);
      m_scl = 1'b0;
      if (i == 0 && exp_ack) begin
        if (kind == 1) m_idx = b;
        if (kind == 2) begin
          if (m_idx < NC) exp_ctrl[m_idx] = b;
          m_idx = (m_idx + 1) % 256;
        end
      end
      tk(H/2);
    end
    m_sda = 1'b1;
    m_scl = 1'b1; tk(H/2);
    ack = ~sda_bus;
    check(ack == exp_ack, req, 64'(ack), 64'(exp_ack));
    tk(H/2);
    m_scl = 1'b0; tk(H/2);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit mack, input bit active, input string req);
    logic [7:0] got;
    logic s0;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tk(H/2);
      m_scl = 1'b1; tk(2);
      s0 = sda_bus; tk(H/2 - 2);
      got[i] = sda_bus; tk(H/2);
      check(sda_bus == s0, "R10 line steady while clock high", 64'(sda_bus), 64'(s0));
      m_scl = 1'b0;
    end
    if (active) m_idx = (m_idx + 1) % 256;
    tk(H/2);
    m_sda = ~mack; tk(H/2);
    m_scl = 1'b1; tk(H);
    m_scl = 1'b0; tk(2);
    m_sda = 1'b1; tk(H/2 - 2);
    check(got == exp, req, 64'(got), 64'(exp));
  endtask

  task automatic set_index(input logic [7:0] i);
    bus_start();
    send_byte(8'h24, 1'b1, 0, "R3 write address ack");
    send_byte(i, 1'b1, 1, "R4 index ack");
  endtask

  initial begin
    for (int i = 0; i < NC; i++) exp_ctrl[i] = INIT[i*8 +: 8];
    tk(5);
    check(ctrl == INIT, "R8 reset control values", ctrl, INIT);
    check(sda_pull == 1'b0, "R8 reset pull off", 64'(sda_pull), 64'h0);
    rst_n = 1'b1;
    tk(5);

    // R4: burst write from index 2
    set_index(8'h02);
    send_byte(8'hA5, 1'b1, 2, "R4 data ack");
    send_byte(8'h3C, 1'b1, 2, "R4 data ack");
    send_byte(8'h77, 1'b1, 2, "R4 data ack");
    bus_stop();

    // R6/R7: read after stop, master ack continues, nack ends
    set_index(8'h01);
    bus_stop();
    bus_start();
    send_byte(8'h25, 1'b1, 0, "R3 read address ack");
    recv_byte(exp_rd(m_idx), 1'b1, 1'b1, "R6 read byte");
    recv_byte(exp_rd(m_idx), 1'b1, 1'b1, "R6 read byte");
    recv_byte(exp_rd(m_idx), 1'b1, 1'b1, "R6 read byte");
    recv_byte(exp_rd(m_idx), 1'b0, 1'b1, "R6 read byte before nack");
    recv_byte(8'hFF, 1'b0, 1'b0, "R7 silent after master nack");
    bus_stop();

    // R6: index kept across stop
    bus_start();
    send_byte(8'h25, 1'b1, 0, "R3 read address ack");
    recv_byte(8'h32, 1'b0, 1'b1, "R6 index kept across stop");
    bus_stop();

    // R5: writes to status and unmapped indices
    set_index(8'h07);
    send_byte(8'hC3, 1'b1, 2, "R4 data ack");
    send_byte(8'h11, 1'b1, 2, "R5 status write acked");
    send_byte(8'h22, 1'b1, 2, "R5 status write acked");
    bus_stop();
    set_index(8'h0E);
    send_byte(8'h33, 1'b1, 2, "R5 unmapped write acked");
    bus_stop();

    // R1/R6: repeated start into read covering control, status, unmapped
    set_index(8'h06);
    bus_start();
    send_byte(8'h25, 1'b1, 0, "R1 read address after repeated start");
    for (int k = 0; k < 6; k++) recv_byte(exp_rd(m_idx), 1'b1, 1'b1, "R6 mapped read");
    recv_byte(8'h00, 1'b0, 1'b1, "R6 unmapped reads zero");
    bus_stop();

    // R3: foreign address ignored
    bus_start();
    send_byte(8'h30, 1'b0, 0, "R3 foreign address no ack");
    send_byte(8'h00, 1'b0, 1, "R3 ignored after foreign address");
    send_byte(8'h99, 1'b0, 2, "R3 ignored after foreign address");
    bus_stop();

    // R2: bytes after a stop are ignored
    set_index(8'h00);
    send_byte(8'h5A, 1'b1, 2, "R4 data ack");
    bus_stop();
    m_scl = 1'b0; tk(H/2);
    send_byte(8'h24, 1'b0, 0, "R2 no ack without start");
    send_byte(8'h44, 1'b0, 2, "R2 no write without start");
    bus_stop();

    // R1: repeated start in the middle of a write
    set_index(8'h05);
    send_byte(8'h99, 1'b1, 2, "R4 data ack");
    set_index(8'h06);
    send_byte(8'h42, 1'b1, 2, "R1 write after repeated start");
    bus_stop();

    // R9: index wraps from FFh to 00h
    set_index(8'hFF);
    send_byte(8'h55, 1'b1, 2, "R9 write at FFh acked");
    send_byte(8'h66, 1'b1, 2, "R9 write wraps to 00h");
    bus_stop();
    set_index(8'hFF);
    bus_start();
    send_byte(8'h25, 1'b1, 0, "R3 read address ack");
    recv_byte(8'h00, 1'b1, 1'b1, "R9 read at FFh");
    recv_byte(8'h66, 1'b0, 1'b1, "R9 read wraps to 00h");
    bus_stop();

    tk(20);
    check(ctrl == exp_vec(), "R4 final control bank", ctrl, exp_vec());
    check(sda_pull == 1'b0, "R2 line released at end", 64'(sda_pull), 64'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule